// File: doc/BRIEF.md
# UART Receive Holding Register with Overrun Control

This block sits between the character deserializer of a UART receiver and the processor bus. Each time the deserializer completes a character it raises a one-cycle strobe with the character. If the one-entry holding register is empty and no overrun is pending, the block stores the character and raises a receive-full flag. A data-register read strobe returns the held character and empties the register.

A character that completes while the holding register is still full, or while an earlier overrun is unresolved, is dropped. The held character stays intact and the overrun flag sets. The overrun flag clears only through a two-step sequence: a status-register read first, then a data-register read. A new loss that occurs between the two steps cancels the sequence.

A single interrupt output combines the receive-full and overrun conditions with three enable inputs.

Top module: `uart_rx_holding`

## Requirements
- R1: After reset, `rx_full_o`, `overrun_o` and `irq_o` are 0.
- R2: When a character completes with the register empty and `overrun_o` clear, `rx_full_o` is 1 on the next cycle and `rd_data_o` equals that character.
- R3: A data read (`data_rd_i`=1) with no character completing in the same cycle makes `rx_full_o` 0 on the next cycle. The read data is `rd_data_o` as seen in the read cycle.
- R4: A character that completes while `rx_full_o` is 1 leaves `rd_data_o` unchanged and sets `overrun_o` on the next cycle.
- R5: While `overrun_o` is 1, every completing character is dropped, even when the register is empty. `rx_full_o` and `rd_data_o` do not change.
- R6: A character that completes in the same cycle as a data read of a full register counts as an overrun. On the next cycle `rx_full_o`=0 and `overrun_o`=1, and the holding register is not reloaded.
- R7: `overrun_o` clears only on a data read that follows an earlier status read (`stat_rd_i`=1) with no loss in between. A data read before any status read leaves it set.
- R8: A character lost after the status read and before the data read cancels the armed status read, so the following data read leaves `overrun_o` at 1.
- R9: `irq_o` = (`rx_ie_i` AND (`rx_full_o` OR `overrun_o`)) OR (`err_ie_i` AND `dma_rx_en_i` AND `overrun_o`), evaluated combinationally from the current flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| char_valid_i | input | 1 | One-cycle strobe: deserializer completed a character |
| char_data_i | input | DATA_W | Completed character |
| stat_rd_i | input | 1 | Status-register read strobe |
| data_rd_i | input | 1 | Data-register read strobe |
| rx_ie_i | input | 1 | Receive interrupt enable |
| err_ie_i | input | 1 | Error interrupt enable |
| dma_rx_en_i | input | 1 | DMA receive enable |
| rd_data_o | output | DATA_W | Held character |
| rx_full_o | output | 1 | Receive-full flag |
| overrun_o | output | 1 | Overrun flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Every strobe takes effect in the cycle after the clock edge that samples it, because each flag and the holding register pass through exactly one register. `irq_o` follows the flags and enables with no further delay. The bench drives inputs two nanoseconds after a rising edge and holds each strobe for one cycle. A behavioural model advances at the same edges as the design, and all four outputs are compared with it at every falling edge. Directed checks are made just after the edge that follows each strobe, which is where R2 through R8 predict the new values.

// File: rtl/uart_rxh_pkg.sv
package uart_rxh_pkg;

    // Overrun tracking: the flag itself and the armed status-read step.
    typedef struct packed {
        logic ovr;
        logic armed;
    } ovr_state_t;

    // Decoded per-cycle receive events.
    typedef struct packed {
        logic accept;
        logic lost;
    } rx_event_t;

endpackage

// File: rtl/rxh_hold_reg.sv
module rxh_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              drain_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              full_o,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.full = 1'b1;
            st_d.data = data_i;
        end else if (drain_i) begin
            st_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign full_o = st_q.full;
    assign data_o = st_q.data;

endmodule

// File: rtl/rxh_ovr_ctl.sv
module rxh_ovr_ctl
    import uart_rxh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lost_i,
    input  logic stat_rd_i,
    input  logic data_rd_i,
    output logic ovr_o
);

    ovr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // A loss always wins: it sets the flag and disarms the clear sequence.
        if (lost_i) begin
            st_d.ovr   = 1'b1;
            st_d.armed = 1'b0;
        end else begin
            if (data_rd_i && st_q.armed) begin
                st_d.ovr = 1'b0;
            end
            if (stat_rd_i) begin
                st_d.armed = 1'b1;
            end else if (data_rd_i) begin
                st_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ovr_o = st_q.ovr;

endmodule

// File: rtl/rxh_irq.sv
module rxh_irq (
    input  logic full_i,
    input  logic ovr_i,
    input  logic rx_ie_i,
    input  logic err_ie_i,
    input  logic dma_rx_en_i,
    output logic irq_o
);

    logic rx_src, err_src;

    always_comb begin
        rx_src  = rx_ie_i & (full_i | ovr_i);
        err_src = err_ie_i & dma_rx_en_i & ovr_i;
        irq_o   = rx_src | err_src;
    end

endmodule

// File: rtl/uart_rx_holding.sv
module uart_rx_holding
    import uart_rxh_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_valid_i,
    input  logic [DATA_W-1:0] char_data_i,
    input  logic              stat_rd_i,
    input  logic              data_rd_i,
    input  logic              rx_ie_i,
    input  logic              err_ie_i,
    input  logic              dma_rx_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rx_full_o,
    output logic              overrun_o,
    output logic              irq_o
);

    rx_event_t ev;
    logic      full_q;
    logic      ovr_q;

    // Accept only into an empty register with no overrun pending;
    // a character meeting a full register (even one being read) is lost.
    always_comb begin
        ev.accept = char_valid_i & ~full_q & ~ovr_q;
        ev.lost   = char_valid_i & (full_q | ovr_q);
    end

    rxh_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (ev.accept),
        .drain_i (data_rd_i),
        .data_i  (char_data_i),
        .full_o  (full_q),
        .data_o  (rd_data_o)
    );

    rxh_ovr_ctl u_ovr (
        .clk       (clk),
        .rst_n     (rst_n),
        .lost_i    (ev.lost),
        .stat_rd_i (stat_rd_i),
        .data_rd_i (data_rd_i),
        .ovr_o     (ovr_q)
    );

    rxh_irq u_irq (
        .full_i      (full_q),
        .ovr_i       (ovr_q),
        .rx_ie_i     (rx_ie_i),
        .err_ie_i    (err_ie_i),
        .dma_rx_en_i (dma_rx_en_i),
        .irq_o       (irq_o)
    );

    assign rx_full_o = full_q;
    assign overrun_o = ovr_q;

endmodule

// File: rtl/uart_rxh_chk.sv
module uart_rxh_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              char_valid_i,
    input logic [DATA_W-1:0] char_data_i,
    input logic              stat_rd_i,
    input logic              data_rd_i,
    input logic              rx_ie_i,
    input logic              err_ie_i,
    input logic              dma_rx_en_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              rx_full_o,
    input logic              overrun_o,
    input logic              irq_o
);

    // R2
    accept_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid_i && !rx_full_o && !overrun_o)
        |=> (rx_full_o && rd_data_o == $past(char_data_i)));

    // R3
    read_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd_i && !char_valid_i) |=> !rx_full_o);

    // R4
    held_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid_i && rx_full_o) |=> (overrun_o && $stable(rd_data_o)));

    // R5
    drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid_i && overrun_o && !data_rd_i) |=> ($stable(rx_full_o) && $stable(rd_data_o)));

    // R7
    clear_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(overrun_o) |-> $past(data_rd_i));

    // R9
    irq_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ie_i && (rx_full_o || overrun_o)) |-> irq_o);

    // R9
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_full_o && !overrun_o) |-> !irq_o);

endmodule

bind uart_rx_holding uart_rxh_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_uart_rx_holding.sv
module tb_uart_rx_holding;

    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              char_valid_i = 1'b0;
    logic [DATA_W-1:0] char_data_i = '0;
    logic              stat_rd_i = 1'b0;
    logic              data_rd_i = 1'b0;
    logic              rx_ie_i = 1'b0;
    logic              err_ie_i = 1'b0;
    logic              dma_rx_en_i = 1'b0;
    logic [DATA_W-1:0] rd_data_o;
    logic              rx_full_o;
    logic              overrun_o;
    logic              irq_o;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // Behavioural reference state
    int m_data = 0;
    bit m_full = 1'b0;
    bit m_ovr  = 1'b0;
    bit m_arm  = 1'b0;
    int lost_q[$];

    uart_rx_holding #(.DATA_W(DATA_W)) dut (.*);

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: advances at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_full = 0; m_ovr = 0; m_arm = 0; m_data = 0;
        end else begin
            bit was_full, was_ovr, was_arm;
            was_full = m_full; was_ovr = m_ovr; was_arm = m_arm;
            if (char_valid_i) begin
                if (was_full || was_ovr) begin
                    lost_q.push_back(int'(char_data_i));
                    m_ovr = 1;
                    m_arm = 0;
                    if (data_rd_i) m_full = 0;
                end else begin
                    m_data = int'(char_data_i);
                    m_full = 1;
                    if (stat_rd_i) m_arm = 1;
                    else if (data_rd_i) m_arm = 0;
                end
            end else begin
                if (data_rd_i) begin
                    m_full = 0;
                    if (was_arm) m_ovr = 0;
                end
                if (stat_rd_i) m_arm = 1;
                else if (data_rd_i) m_arm = 0;
            end
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit exp_irq;
            exp_irq = (rx_ie_i && (m_full || m_ovr)) || (err_ie_i && dma_rx_en_i && m_ovr);
            check(rx_full_o == m_full, "R2/R3 rx_full", int'(rx_full_o), int'(m_full));
            check(overrun_o == m_ovr, "R7 overrun", int'(overrun_o), int'(m_ovr));
            check(int'(rd_data_o) == m_data, "R4 rd_data", int'(rd_data_o), m_data);
            check(irq_o == exp_irq, "R9 irq", int'(irq_o), int'(exp_irq));
        end
    end

    // Drive one cycle of strobes, return just after the sampling edge
    task automatic apply(input bit v, input int d, input bit st, input bit rd);
        char_valid_i = v;
        char_data_i  = d[DATA_W-1:0];
        stat_rd_i    = st;
        data_rd_i    = rd;
        @(posedge clk); #2;
        char_valid_i = 0;
        stat_rd_i    = 0;
        data_rd_i    = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(posedge clk); #2;
        // R1
        check(!rx_full_o && !overrun_o && !irq_o, "R1 reset", int'({rx_full_o, overrun_o, irq_o}), 0);

        // Normal receive (R2, R3)
        apply(1, 'h3C, 0, 0);
        check(rx_full_o && rd_data_o == 8'h3C, "R2 accept", int'(rd_data_o), 'h3C);
        apply(0, 0, 0, 1);
        check(!rx_full_o, "R3 drain", int'(rx_full_o), 0);

        // Back-to-back overrun (R4, R5, R7)
        apply(1, 'hA1, 0, 0);
        apply(1, 'hB2, 0, 0);
        check(overrun_o && rd_data_o == 8'hA1, "R4 keep held", int'(rd_data_o), 'hA1);
        apply(1, 'hC3, 0, 0);
        check(rd_data_o == 8'hA1 && rx_full_o, "R5 drop while full", int'(rd_data_o), 'hA1);
        apply(0, 0, 1, 0);
        apply(0, 0, 0, 1);
        check(!overrun_o && !rx_full_o, "R7 ordered clear", int'(overrun_o), 0);
        apply(1, 'h44, 0, 0);
        check(rx_full_o && rd_data_o == 8'h44, "R2 accept after clear", int'(rd_data_o), 'h44);

        // Out-of-order clear (R7) and drop into empty register (R5)
        apply(1, 'h55, 0, 0);
        apply(0, 0, 0, 1);
        check(overrun_o && !rx_full_o, "R7 data read first", int'(overrun_o), 1);
        apply(1, 'h66, 0, 0);
        check(!rx_full_o && rd_data_o == 8'h44, "R5 drop while empty", int'(rd_data_o), 'h44);
        apply(0, 0, 1, 0);
        check(overrun_o, "R7 status alone", int'(overrun_o), 1);
        apply(0, 0, 0, 1);
        check(!overrun_o, "R7 late clear", int'(overrun_o), 0);

        // Coincident read and completion (R6), then canceled clear (R8)
        apply(1, 'h77, 0, 0);
        apply(1, 'h88, 0, 1);
        check(!rx_full_o && overrun_o && rd_data_o == 8'h77, "R6 coincident", int'(rd_data_o), 'h77);
        apply(0, 0, 1, 0);
        apply(1, 'h99, 0, 0);
        apply(0, 0, 0, 1);
        check(overrun_o, "R8 canceled clear", int'(overrun_o), 1);
        apply(0, 0, 1, 0);
        apply(0, 0, 0, 1);
        check(!overrun_o, "R8 re-armed clear", int'(overrun_o), 0);

        // Interrupt combinations (R9)
        rx_ie_i = 1;
        apply(1, 'h12, 0, 0);
        check(irq_o, "R9 rx enable", int'(irq_o), 1);
        rx_ie_i = 0; #1;
        check(!irq_o, "R9 no enable", int'(irq_o), 0);
        apply(1, 'h13, 0, 0);
        err_ie_i = 1; #1;
        check(!irq_o, "R9 err without dma", int'(irq_o), 0);
        dma_rx_en_i = 1; #1;
        check(irq_o, "R9 err and dma", int'(irq_o), 1);
        check(lost_q.size() == 7, "R5 lost count", lost_q.size(), 7);
        apply(0, 0, 1, 0);
        apply(0, 0, 0, 1);
        check(!irq_o, "R9 cleared", int'(irq_o), 0);

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 5000);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule